// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block places accepted receive frames into a circular region of local packet memory that is divided into 256-byte pages. Software supplies the first page of the ring, the page one past its last page and a boundary page that marks how far the reader has consumed. The block keeps the current page pointer, which software may also load. Frame bytes arrive on a byte stream with start and end markers. The block writes them through a plain byte write port, fills short frames up to the minimum length, and wraps the data at the end of the ring.

When a frame ends, the block writes a 4-byte header at the base of the frame's first page. The header holds the status, the page where the next frame will start, and the stored length. The block then moves the current page to that next page and pulses a done signal. A combinational full flag tells upstream logic whether the ring still has room for a worst-case frame. A frame that starts while the ring is full or while the halt input is set is consumed and discarded.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `in_ready_o`=1, `mem_we_o`=0, `rx_done_o`=0 and `cur_pg_o`=0.
- R2: `full_o` is 1 whenever `stop_pg_i` <= `start_pg_i`.
- R3: With current page C and boundary page B, free pages are B-C if C<B, otherwise (stop-start)-(C-B). `full_o` is 1 when the free pages times 256 is below 1518, so 5 free pages is full and 6 is not.
- R4: The header occupies bytes 0..3 of the frame's base page. Byte 0 is the status, byte 1 the next page, and bytes 2 and 3 the total length as low byte then high byte. The total length is the stored data length plus 4.
- R5: The status byte is 0x01, with bit 5 (0x20) also set when bit 0 of the first frame byte is 1.
- R6: Frames shorter than 60 bytes are followed by zero bytes up to 60 stored data bytes. Data starts at offset 4 of the base page.
- R7: The next page is base + floor((total+4+255)/256); if that is >= stop, then stop-start is subtracted.
- R8: A data write address that reaches stop*256 continues at start*256.
- R9: If the current page is >= `PMEM_END_PG` (default 0x80), the frame's base page is the start page.
- R10: A frame whose first byte is accepted while `halt_i`=1 or `full_o`=1 is consumed (ready held high) without memory writes, done pulse or change of the current page.
- R11: After a frame is stored, `cur_pg_o` shows the next page and `rx_done_o` is high for exactly one cycle. That cycle is the one after the last header write.
- R12: While padding or header bytes are written, `in_ready_o` is 0.
- R13: A pulse on `cur_pg_ld_i` loads `cur_pg_i` into the current page pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pg_i | input | 8 | First page of the ring |
| stop_pg_i | input | 8 | Page one past the last ring page |
| bnry_pg_i | input | 8 | Boundary page (reader position) |
| halt_i | input | 1 | Refuse new frames |
| cur_pg_ld_i | input | 1 | Load the current page pointer |
| cur_pg_i | input | 8 | Value for the current page load |
| cur_pg_o | output | 8 | Current page pointer |
| full_o | output | 1 | Ring lacks room for a worst-case frame |
| in_valid_i | input | 1 | Stream byte valid |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Stream byte accepted when valid |
| mem_we_o | output | 1 | Packet memory write strobe |
| mem_addr_o | output | 16 | Packet memory byte address |
| mem_wdata_o | output | 8 | Packet memory write data |
| rx_done_o | output | 1 | One-cycle frame stored pulse |

## Verification
Data bytes are written in the same cycle the stream byte is accepted. The last accepted byte is followed by 60-n padding cycles for a short frame of n bytes, then 4 header cycles. The done pulse and the new current page appear in the cycle after that, so the done pulse is due at the (pad+5)th falling edge after the last byte's rising edge. The bench counts falling edges from that point and compares the count with this figure. It checks ready low at the first edge and done low again one edge after the pulse. Refused frames are observed for 100 cycles without writes or done, and the full flag is sampled one edge after each configuration change.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_HDR
  } rxr_state_e;

  localparam int PAGE_BITS = 8;
  localparam logic [7:0] STAT_OK    = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_free_space.sv
module rxr_free_space #(
  parameter int PG_W   = 8,
  parameter int MARGIN = 1518
) (
  input  logic [PG_W-1:0] start_pg_i,
  input  logic [PG_W-1:0] stop_pg_i,
  input  logic [PG_W-1:0] bnry_pg_i,
  input  logic [PG_W-1:0] cur_pg_i,
  output logic            full_o
);
  localparam int SW = PG_W + 2;
  localparam int BW = SW + rxr_pkg::PAGE_BITS;
  localparam logic signed [BW-1:0] MARGIN_S = BW'(MARGIN);

  logic signed [SW-1:0] s_start, s_stop, s_bnry, s_cur, pages;
  logic signed [BW-1:0] bytes;

  always_comb begin
    s_start = signed'({2'b00, start_pg_i});
    s_stop  = signed'({2'b00, stop_pg_i});
    s_bnry  = signed'({2'b00, bnry_pg_i});
    s_cur   = signed'({2'b00, cur_pg_i});
    if (s_cur < s_bnry) pages = s_bnry - s_cur;
    else                pages = (s_stop - s_start) - (s_cur - s_bnry);
    bytes  = signed'({pages, {rxr_pkg::PAGE_BITS{1'b0}}});
    full_o = (stop_pg_i <= start_pg_i) || (bytes < MARGIN_S);
  end
endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
  parameter int PG_W  = 8,
  parameter int LEN_W = 16
) (
  input  logic [PG_W-1:0]  base_pg_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic [PG_W-1:0]  start_pg_i,
  input  logic [PG_W-1:0]  stop_pg_i,
  output logic [PG_W-1:0]  next_pg_o
);
  localparam int W = LEN_W + 1;
  // trailing 4 bytes reserved, then round up to whole pages
  localparam logic [W-1:0] ROUND = W'((1 << rxr_pkg::PAGE_BITS) + 3);

  logic [W-1:0] adv, sum;

  always_comb begin
    adv = ({1'b0, total_i} + ROUND) >> rxr_pkg::PAGE_BITS;
    sum = W'(base_pg_i) + adv;
    if (sum >= W'(stop_pg_i)) sum = sum - (W'(stop_pg_i) - W'(start_pg_i));
    next_pg_o = sum[PG_W-1:0];
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 16,
  parameter int MIN_FRAME   = 60,
  parameter int MAX_FRAME   = 1514,
  parameter int PMEM_END_PG = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        start_pg_i,
  input  logic [7:0]        stop_pg_i,
  input  logic [7:0]        bnry_pg_i,
  input  logic              halt_i,
  input  logic              cur_pg_ld_i,
  input  logic [7:0]        cur_pg_i,
  output logic [7:0]        cur_pg_o,
  output logic              full_o,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              rx_done_o
);
  import rxr_pkg::*;

  localparam int PG_W   = ADDR_W - PAGE_BITS;
  localparam int HDR_B  = 4;
  localparam int MARGIN = MAX_FRAME + HDR_B;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  rxr_state_e        state_q;
  logic [PG_W-1:0]   cur_pg_q, base_pg_q, base_pg, next_pg;
  logic [ADDR_W-1:0] wr_addr_q, first_addr;
  logic [LEN_W-1:0]  cnt_q, cnt_inc, total;
  logic [1:0]        hdr_idx_q;
  logic              group_q, done_q, accept, refuse;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [PG_W-1:0]   s,
                                                  input logic [PG_W-1:0]   e);
    logic [ADDR_W-1:0] n;
    n = a + 1'b1;
    if (n == {e, {PAGE_BITS{1'b0}}}) n = {s, {PAGE_BITS{1'b0}}};
    return n;
  endfunction

  rxr_free_space #(.PG_W(PG_W), .MARGIN(MARGIN)) u_space (
    .start_pg_i (start_pg_i),
    .stop_pg_i  (stop_pg_i),
    .bnry_pg_i  (bnry_pg_i),
    .cur_pg_i   (cur_pg_q),
    .full_o     (full_o)
  );

  rxr_next_page #(.PG_W(PG_W), .LEN_W(LEN_W)) u_next (
    .base_pg_i  (base_pg_q),
    .total_i    (total),
    .start_pg_i (start_pg_i),
    .stop_pg_i  (stop_pg_i),
    .next_pg_o  (next_pg)
  );

  always_comb begin
    base_pg    = (cur_pg_q >= PG_W'(PMEM_END_PG)) ? start_pg_i : cur_pg_q;
    first_addr = {base_pg, {PAGE_BITS{1'b0}}} + ADDR_W'(HDR_B);
    total      = cnt_q + LEN_W'(HDR_B);
    cnt_inc    = cnt_q + 1'b1;
    in_ready_o = (state_q == ST_IDLE) || (state_q == ST_DATA) || (state_q == ST_DROP);
    accept     = in_valid_i && in_ready_o;
    refuse     = halt_i || full_o;
    mem_we_o    = 1'b0;
    mem_addr_o  = wr_addr_q;
    mem_wdata_o = in_data_i;
    unique case (state_q)
      ST_IDLE: begin
        mem_we_o   = accept && in_sof_i && !refuse;
        mem_addr_o = first_addr;
      end
      ST_DATA: mem_we_o = accept;
      ST_PAD: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = 8'h00;
      end
      ST_HDR: begin
        mem_we_o   = 1'b1;
        mem_addr_o = {base_pg_q, PAGE_BITS'(hdr_idx_q)};
        unique case (hdr_idx_q)
          2'd0:    mem_wdata_o = STAT_OK | (group_q ? STAT_GROUP : 8'h00);
          2'd1:    mem_wdata_o = next_pg;
          2'd2:    mem_wdata_o = total[7:0];
          default: mem_wdata_o = total[15:8];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cur_pg_q  <= '0;
      base_pg_q <= '0;
      wr_addr_q <= '0;
      cnt_q     <= '0;
      hdr_idx_q <= '0;
      group_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cur_pg_ld_i) cur_pg_q <= cur_pg_i;
      unique case (state_q)
        ST_IDLE: if (accept && in_sof_i) begin
          if (refuse) begin
            if (!in_eof_i) state_q <= ST_DROP;
          end else begin
            base_pg_q <= base_pg;
            group_q   <= in_data_i[0];
            cnt_q     <= LEN_W'(1);
            hdr_idx_q <= '0;
            wr_addr_q <= step_addr(first_addr, start_pg_i, stop_pg_i);
            state_q   <= in_eof_i ? ST_PAD : ST_DATA;
          end
        end
        ST_DATA: if (accept) begin
          cnt_q     <= cnt_inc;
          wr_addr_q <= step_addr(wr_addr_q, start_pg_i, stop_pg_i);
          if (in_eof_i) state_q <= (cnt_inc < MIN_LEN) ? ST_PAD : ST_HDR;
        end
        ST_PAD: begin
          cnt_q     <= cnt_inc;
          wr_addr_q <= step_addr(wr_addr_q, start_pg_i, stop_pg_i);
          if (cnt_inc >= MIN_LEN) state_q <= ST_HDR;
        end
        ST_HDR: begin
          hdr_idx_q <= hdr_idx_q + 1'b1;
          if (hdr_idx_q == 2'd3) begin
            cur_pg_q <= next_pg;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        ST_DROP: if (accept && in_eof_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_pg_o  = cur_pg_q;
  assign rx_done_o = done_q;
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        start_pg_i,
  input logic [7:0]        stop_pg_i,
  input logic              full_o,
  input logic              in_ready_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rx_done_o
);
  assert_degenerate_ring_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_pg_i <= start_pg_i) |-> full_o);

  assert_no_write_at_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (start_pg_i < stop_pg_i)) |-> (mem_addr_o[ADDR_W-1:8] != stop_pg_i));

  assert_done_after_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(mem_we_o));

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  assert_done_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> in_ready_o);

  assert_stall_writes_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> mem_we_o);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_pg_i (start_pg_i),
  .stop_pg_i  (stop_pg_i),
  .full_o     (full_o),
  .in_ready_o (in_ready_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .rx_done_o  (rx_done_o)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  start_pg = 8'h46, stop_pg = 8'h60, bnry_pg = 8'h46;
  logic        halt = 1'b0, ld = 1'b0;
  logic [7:0]  ld_pg = 8'h00, cur_pg;
  logic        full, in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_ready;
  logic [7:0]  in_data = 8'h00, mem_wdata;
  logic        mem_we, done;
  logic [15:0] mem_addr;

  int n_chk = 0, n_bad = 0, wr_cnt = 0;
  logic [7:0] mem_q [int unsigned];

  always #2.5 clk = ~clk;

  rx_ring_writer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_pg_i(start_pg), .stop_pg_i(stop_pg),
    .bnry_pg_i(bnry_pg), .halt_i(halt), .cur_pg_ld_i(ld), .cur_pg_i(ld_pg),
    .cur_pg_o(cur_pg), .full_o(full), .in_valid_i(in_valid), .in_sof_i(in_sof),
    .in_eof_i(in_eof), .in_data_i(in_data), .in_ready_o(in_ready),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .rx_done_o(done)
  );

  always @(posedge clk) if (rst_n && mem_we) begin
    mem_q[int'(mem_addr)] = mem_wdata;
    wr_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i, logic [7:0] first, logic [7:0] seed);
    return (i == 0) ? first : 8'(seed + i * 7);
  endfunction

  function automatic int rd(int a);
    return mem_q.exists(a) ? int'(mem_q[a]) : 'h1ff;
  endfunction

  task automatic set_cfg(input logic [7:0] s, input logic [7:0] e, input logic [7:0] b);
    @(negedge clk);
    start_pg = s; stop_pg = e; bnry_pg = b;
    @(negedge clk);
  endtask

  task automatic load_cur(input logic [7:0] p);
    @(negedge clk); ld = 1'b1; ld_pg = p;
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] first, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(i, first, seed);
      in_sof = (i == 0); in_eof = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    #1 in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // send, then verify timing, pointer, header and data of a stored frame
  task automatic accept_case(input int n, input logic [7:0] first, input logic [7:0] seed,
                             input int base, input int exp_next, input int exp_stat);
    int stored, total, pad, k, w0, a, bad, got;
    stored = (n < 60) ? 60 : n;
    total  = stored + 4;
    pad    = stored - n;
    mem_q.delete();
    w0 = wr_cnt;
    send_frame(n, first, seed);
    k = 0;
    for (int c = 1; c <= 2000; c++) begin
      @(negedge clk);
      if (c == 1) chk("R12 ready low after last byte", int'(in_ready), 0);
      if (done) begin k = c; break; end
    end
    chk("R11 done cycle", k, pad + 5);
    chk("R11 current page", int'(cur_pg), exp_next);
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
    chk("R6 write count", wr_cnt - w0, total);
    chk("R5 status byte", rd(base * 256), exp_stat);
    chk("R7 next page in header", rd(base * 256 + 1), exp_next);
    chk("R4 length low", rd(base * 256 + 2), total & 'hff);
    chk("R4 length high", rd(base * 256 + 3), total >> 8);
    a = base * 256 + 4;
    bad = 0;
    for (int i = 0; i < stored; i++) begin
      got = rd(a);
      if (bad == 0 && got != ((i < n) ? int'(pat(i, first, seed)) : 0)) begin
        bad = 1;
        chk((i < n) ? "R8 data byte" : "R6 pad byte", got,
            (i < n) ? int'(pat(i, first, seed)) : 0);
      end
      a++;
      if (a == int'(stop_pg) * 256) a = int'(start_pg) * 256;
    end
    if (bad == 0) chk("R8 data bytes", 0, 0);
  endtask

  task automatic refuse_case(input string tag, input int n);
    int w0, seen;
    logic [7:0] c0;
    w0 = wr_cnt; c0 = cur_pg; seen = 0;
    send_frame(n, 8'h00, 8'h33);
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk({tag, " no writes"}, wr_cnt - w0, 0);
    chk({tag, " no done"}, seen, 0);
    chk({tag, " page kept"}, int'(cur_pg), int'(c0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 we", int'(mem_we), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 cur page", int'(cur_pg), 0);
  endtask

  task automatic t_frames();
    load_cur(8'h46);
    chk("R13 load", int'(cur_pg), 'h46);
    accept_case(20, 8'h00, 8'h10, 'h46, 'h47, 'h01);   // short, padded
    accept_case(100, 8'h01, 8'h20, 'h47, 'h48, 'h21);  // group bit set
    accept_case(600, 8'h02, 8'h30, 'h48, 'h4b, 'h01);  // multi-page
  endtask

  task automatic t_full();
    set_cfg(8'h46, 8'h60, 8'h50);                       // cur 4b: 5 pages
    chk("R3 five pages full", int'(full), 1);
    refuse_case("R10 full", 30);
    set_cfg(8'h46, 8'h60, 8'h51);                       // 6 pages
    chk("R3 six pages free", int'(full), 0);
    load_cur(8'h5c);
    set_cfg(8'h46, 8'h60, 8'h46);                       // 1a-16 = 4 pages
    chk("R3 cur past boundary full", int'(full), 1);
    set_cfg(8'h46, 8'h60, 8'h5c);
    chk("R3 cur equals boundary empty", int'(full), 0);
    set_cfg(8'h46, 8'h46, 8'h46);
    chk("R2 stop equals start", int'(full), 1);
    set_cfg(8'h46, 8'h40, 8'h46);
    chk("R2 stop below start", int'(full), 1);
    set_cfg(8'h46, 8'h60, 8'h50);
  endtask

  task automatic t_wrap();
    load_cur(8'h5e);
    accept_case(600, 8'h00, 8'h44, 'h5e, 'h47, 'h01);  // data wraps, next wraps
    load_cur(8'h5f);
    accept_case(60, 8'h00, 8'h55, 'h5f, 'h46, 'h01);   // next lands on stop
  endtask

  task automatic t_halt();
    @(negedge clk); halt = 1'b1;
    refuse_case("R10 halt", 10);
    @(negedge clk); halt = 1'b0;
  endtask

  task automatic t_high_page();
    set_cfg(8'h46, 8'h60, 8'ha0);
    load_cur(8'h90);
    accept_case(30, 8'h00, 8'h66, 'h46, 'h47, 'h01);   // R9 base falls back to start
    accept_case(1, 8'h03, 8'h77, 'h47, 'h48, 'h21);    // one-byte frame
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frames();
    t_full();
    t_wrap();
    t_halt();
    t_high_page();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule